// File: doc/BRIEF.md
# Receive buffer area allocation controller

This block does the buffer bookkeeping on the receive side of a network controller. The host programs a small register set through a synchronous register port. That set covers a word-count threshold, the upper half of the resource ring address, the ring's start and end pointers, a read pointer, a write pointer and a combined sequence register. Each time a frame finishes, the receive path reports how many words are still free in the current buffer area. The block then decides whether the following frame fits in the same area or whether a fresh area must be taken from the resource ring.

When a fresh area is needed, the block flags the last frame of the area. It raises a fetch request carrying the full 32-bit address of the next resource descriptor and waits for the DMA side to acknowledge. On the acknowledge it steps the read pointer one descriptor forward, wrapping at the ring end, and bumps the area sequence number. If the read pointer has caught up with the write pointer, the request is held back and a resources-exhausted flag is shown instead, until the host adds descriptors by moving the write pointer.

Top module: `rx_bufarea_ctrl`

## Requirements
- R1: A hardware reset (rst_n low) sets the threshold register to 16'h02F8 and the sequence register to 16'h0000; the ring registers keep whatever they held.
- R2: At a frame end where the threshold is less than or equal to the reported free words, the next frame stays in the same area: no last-frame flag, no fetch request and no exhausted flag follow.
- R3: At a frame end where the threshold exceeds the reported free words, last_in_area is high for exactly the following cycle and a new area stays pending until it is taken.
- R4: Every frame end adds one, modulo 256, to the packet count in sequence bits [7:0] and leaves bits [15:8] unchanged, unless an area is taken or the host writes the sequence register in that cycle.
- R5: Taking an area (fetch_req and fetch_ack high together) clears sequence bits [7:0] and adds one, modulo 256, to the area count in bits [15:8].
- R6: Register map by reg_addr: 0 threshold, 1 upper resource half, 2 ring start, 3 ring end, 4 read pointer, 5 write pointer, 6 sequence, 7 reads as zero. Bit 0 of the four pointer registers is not stored and reads as 0.
- R7: While fetch_req is high, fetch_addr equals {upper resource half, read pointer}.
- R8: Each area taken advances the read pointer by 8 (wide_mode low) or 16 (wide_mode high); if the advanced value equals the ring end it becomes the ring start instead.
- R9: While an area is pending and the read pointer equals the write pointer, rsrc_exhausted is high, fetch_req is low and fetch_ack has no effect; the request resumes once the pointers differ.
- R10: With wide_mode high, a host write to the write pointer stores bit 1 as 0.
- R11: A host write to the sequence register takes the written value, zero included, and overrides a same-cycle frame-end or area-take update.
- R12: reg_rdata shows the register that reg_addr selected at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wide_mode | input | 1 | 1: 32-bit memory mode (16-byte descriptors), 0: 16-bit mode (8-byte descriptors) |
| reg_we | input | 1 | Host register write enable |
| reg_addr | input | 3 | Host register select |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered host read data |
| pkt_end | input | 1 | One-cycle pulse at the end of a received frame |
| pkt_rem_words | input | 16 | Free words left in the current area, valid with pkt_end |
| fetch_req | output | 1 | Request to read the next resource descriptor |
| fetch_ack | input | 1 | Descriptor fetch accepted; an area is taken |
| fetch_addr | output | 32 | Descriptor address, valid with fetch_req |
| last_in_area | output | 1 | One-cycle flag: the frame just ended was the last in its area |
| rsrc_exhausted | output | 1 | Area pending but the resource ring is empty |

## Verification
The threshold comparison is driven with free-word counts above, exactly equal to, and below the threshold. The equal case separates a less-or-equal test from a strict one, and the below case confirms that the flag and the request appear together. The ring is walked in both descriptor sizes until it reaches the write pointer and then across the end address. This separates the stall from a plain advance and the wrap from running past the end. Sequence updates are driven through long frame runs, an area take from count 255, and host writes that collide with frame ends, which together expose modulo and priority errors.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CNT_W  = HALF_W / 2;

  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_THRESH = 3'd0,
    SEL_UPPER  = 3'd1,
    SEL_START  = 3'd2,
    SEL_END    = 3'd3,
    SEL_RDPTR  = 3'd4,
    SEL_WRPTR  = 3'd5,
    SEL_SEQ    = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  // Next frame must go to a new area when the threshold exceeds the free words.
  function automatic logic f_area_full(input half_t thresh, input half_t free_words);
    return thresh > free_words;
  endfunction

  // Descriptor size in bytes for the current memory width.
  function automatic half_t f_desc_step(input logic wide, input half_t narrow_b,
                                        input half_t wide_b);
    return wide ? wide_b : narrow_b;
  endfunction

  // Ring advance with wrap on reaching the end address.
  function automatic half_t f_ring_next(input half_t cur, input half_t first,
                                        input half_t last, input half_t step);
    half_t nxt;
    nxt = cur + step;
    return (nxt == last) ? first : nxt;
  endfunction

  // Sequence update after an area is taken: packet count clears, area count bumps.
  function automatic half_t f_seq_take(input half_t seq);
    return {seq[HALF_W-1:CNT_W] + 1'b1, {CNT_W{1'b0}}};
  endfunction

  // Sequence update after one more frame in the current area.
  function automatic half_t f_seq_pkt(input half_t seq);
    return {seq[HALF_W-1:CNT_W], seq[CNT_W-1:0] + 1'b1};
  endfunction

endpackage

// File: rtl/rx_host_regs.sv
module rx_host_regs
  import rx_buf_pkg::*;
#(
  parameter logic [15:0] THRESH_RESET = 16'h02F8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    sel,
  input  half_t               wr_data,
  input  half_t               rd_ptr,
  input  half_t               seq,
  output half_t               thresh,
  output half_t               upper,
  output half_t               ring_start,
  output half_t               ring_end,
  output half_t               wr_ptr,
  output half_t               rd_data
);

  localparam int unsigned NPTR = 3;
  localparam int unsigned WRP_IDX = 2;
  localparam logic [SEL_W-1:0] PTR_SEL [NPTR] = '{SEL_START, SEL_END, SEL_WRPTR};

  half_t                thresh_q;
  half_t                upper_q;
  logic [HALF_W-1:1]    ptr_q [NPTR];
  half_t                ptr_full [NPTR];
  half_t                rd_q;

  // Threshold: the only register here with a hardware reset value.
  always_ff @(posedge clk) begin
    if (!rst_n)
      thresh_q <= THRESH_RESET;
    else if (wr_en && sel == SEL_THRESH)
      thresh_q <= wr_data;
  end

  // Upper address half keeps its value across reset.
  always_ff @(posedge clk) begin
    if (wr_en && sel == SEL_UPPER)
      upper_q <= wr_data;
  end

  // Three pointer registers of identical shape; bit 0 is never stored.
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic bit1_in;
    if (g == WRP_IDX) begin : g_wrp
      assign bit1_in = wide ? 1'b0 : wr_data[1];
    end else begin : g_other
      assign bit1_in = wr_data[1];
    end

    always_ff @(posedge clk) begin
      if (wr_en && sel == PTR_SEL[g])
        ptr_q[g] <= {wr_data[HALF_W-1:2], bit1_in};
    end

    assign ptr_full[g] = {ptr_q[g], 1'b0};
  end

  // Registered read port: data follows the select by one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      unique case (reg_sel_e'(sel))
        SEL_THRESH: rd_q <= thresh_q;
        SEL_UPPER:  rd_q <= upper_q;
        SEL_START:  rd_q <= ptr_full[0];
        SEL_END:    rd_q <= ptr_full[1];
        SEL_RDPTR:  rd_q <= rd_ptr;
        SEL_WRPTR:  rd_q <= ptr_full[WRP_IDX];
        SEL_SEQ:    rd_q <= seq;
        SEL_NONE:   rd_q <= '0;
        default:    rd_q <= '0;
      endcase
    end
  end

  assign thresh     = thresh_q;
  assign upper      = upper_q;
  assign ring_start = ptr_full[0];
  assign ring_end   = ptr_full[1];
  assign wr_ptr     = ptr_full[WRP_IDX];
  assign rd_data    = rd_q;

endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr
  import rx_buf_pkg::*;
#(
  parameter int unsigned NARROW_BYTES = 8,
  parameter int unsigned WIDE_BYTES   = 16
) (
  input  logic   clk,
  input  logic   wide,
  input  logic   host_wr,
  input  half_t  host_data,
  input  logic   advance,
  input  half_t  ring_start,
  input  half_t  ring_end,
  input  half_t  wr_ptr,
  output half_t  rd_ptr,
  output logic   ring_empty
);

  localparam half_t STEP_N = half_t'(NARROW_BYTES);
  localparam half_t STEP_W = half_t'(WIDE_BYTES);

  logic [HALF_W-1:1] rd_q;
  half_t             rd_full;
  half_t             rd_next;

  assign rd_full = {rd_q, 1'b0};
  assign rd_next = f_ring_next(rd_full, ring_start, ring_end,
                               f_desc_step(wide, STEP_N, STEP_W));

  // No hardware reset: the host programs the pointer before enabling receive.
  always_ff @(posedge clk) begin
    if (host_wr)
      rd_q <= host_data[HALF_W-1:1];
    else if (advance)
      rd_q <= rd_next[HALF_W-1:1];
  end

  assign rd_ptr     = rd_full;
  assign ring_empty = (rd_full == wr_ptr);

endmodule

// File: rtl/rx_seq_ctr.sv
module rx_seq_ctr
  import rx_buf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   host_wr,
  input  half_t  host_data,
  input  logic   pkt_done,
  input  logic   area_take,
  output half_t  seq
);

  half_t seq_q;

  // Host write wins, then area take, then the per-frame count.
  always_ff @(posedge clk) begin
    if (!rst_n)
      seq_q <= '0;
    else if (host_wr)
      seq_q <= host_data;
    else if (area_take)
      seq_q <= f_seq_take(seq_q);
    else if (pkt_done)
      seq_q <= f_seq_pkt(seq_q);
  end

  assign seq = seq_q;

endmodule

// File: rtl/rx_bufarea_ctrl.sv
module rx_bufarea_ctrl
  import rx_buf_pkg::*;
#(
  parameter logic [15:0] THRESH_RESET       = 16'h02F8,
  parameter int unsigned NARROW_DESC_BYTES  = 8,
  parameter int unsigned WIDE_DESC_BYTES    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        pkt_end,
  input  logic [15:0] pkt_rem_words,
  output logic        fetch_req,
  input  logic        fetch_ack,
  output logic [31:0] fetch_addr,
  output logic        last_in_area,
  output logic        rsrc_exhausted
);

  // Named internal events, also observed by the bound checker.
  half_t thresh_w;
  half_t upper_w;
  half_t start_w;
  half_t end_w;
  half_t wrp_w;
  half_t rdp_w;
  half_t seq_w;
  logic  ring_empty_w;
  logic  need_new_w;
  logic  area_take_w;
  logic  host_wr_seq_w;
  logic  host_wr_rdp_w;
  logic  pending_q;
  logic  last_q;

  assign host_wr_seq_w = reg_we && (reg_addr == SEL_SEQ);
  assign host_wr_rdp_w = reg_we && (reg_addr == SEL_RDPTR);
  assign need_new_w    = pkt_end && f_area_full(thresh_w, pkt_rem_words);
  assign area_take_w   = fetch_req && fetch_ack;

  rx_host_regs #(
    .THRESH_RESET (THRESH_RESET)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wide       (wide_mode),
    .wr_en      (reg_we),
    .sel        (reg_addr),
    .wr_data    (reg_wdata),
    .rd_ptr     (rdp_w),
    .seq        (seq_w),
    .thresh     (thresh_w),
    .upper      (upper_w),
    .ring_start (start_w),
    .ring_end   (end_w),
    .wr_ptr     (wrp_w),
    .rd_data    (reg_rdata)
  );

  rx_ring_ptr #(
    .NARROW_BYTES (NARROW_DESC_BYTES),
    .WIDE_BYTES   (WIDE_DESC_BYTES)
  ) u_ring (
    .clk        (clk),
    .wide       (wide_mode),
    .host_wr    (host_wr_rdp_w),
    .host_data  (reg_wdata),
    .advance    (area_take_w),
    .ring_start (start_w),
    .ring_end   (end_w),
    .wr_ptr     (wrp_w),
    .rd_ptr     (rdp_w),
    .ring_empty (ring_empty_w)
  );

  rx_seq_ctr u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr_seq_w),
    .host_data (reg_wdata),
    .pkt_done  (pkt_end),
    .area_take (area_take_w),
    .seq       (seq_w)
  );

  // A new area stays pending from the overflowing frame end until taken.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      pending_q <= (pending_q && !area_take_w) || need_new_w;
      last_q    <= need_new_w;
    end
  end

  assign fetch_req      = pending_q && !ring_empty_w;
  assign rsrc_exhausted = pending_q && ring_empty_w;
  assign fetch_addr     = {upper_w, rdp_w};
  assign last_in_area   = last_q;

endmodule

// File: rtl/rx_bufarea_ctrl_chk.sv
module rx_bufarea_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wide_mode,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic        pkt_end,
  input logic [15:0] pkt_rem_words,
  input logic [15:0] thresh,
  input logic        last_in_area,
  input logic        fetch_req,
  input logic        fetch_ack,
  input logic        rsrc_exhausted,
  input logic        pending,
  input logic [15:0] rd_ptr,
  input logic [15:0] wr_ptr,
  input logic [15:0] ring_start,
  input logic [15:0] seq,
  input logic        host_wr_seq,
  input logic        host_wr_rdp
);

  AST_OVER_FLAGS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && thresh > pkt_rem_words) |=> last_in_area); // R3

  AST_FIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && thresh <= pkt_rem_words && !pending)
      |=> (!last_in_area && !fetch_req && !rsrc_exhausted)); // R2

  AST_PKT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !(fetch_req && fetch_ack) && !host_wr_seq)
      |=> (seq[7:0] == 8'($past(seq[7:0]) + 8'd1)) && (seq[15:8] == $past(seq[15:8]))); // R4

  AST_AREA_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !host_wr_seq)
      |=> (seq[7:0] == 8'd0) && (seq[15:8] == 8'($past(seq[15:8]) + 8'd1))); // R5

  AST_NO_FETCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (rd_ptr != wr_ptr)); // R9

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !host_wr_rdp)
      |=> (rd_ptr == $past(ring_start)) ||
          (rd_ptr == 16'($past(rd_ptr) + ($past(wide_mode) ? 16'd16 : 16'd8)))); // R8

  AST_PTR_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= 3'd2 && reg_addr <= 3'd5) |=> (reg_rdata[0] == 1'b0)); // R6

endmodule

bind rx_bufarea_ctrl rx_bufarea_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wide_mode      (wide_mode),
  .reg_addr       (reg_addr),
  .reg_rdata      (reg_rdata),
  .pkt_end        (pkt_end),
  .pkt_rem_words  (pkt_rem_words),
  .thresh         (thresh_w),
  .last_in_area   (last_in_area),
  .fetch_req      (fetch_req),
  .fetch_ack      (fetch_ack),
  .rsrc_exhausted (rsrc_exhausted),
  .pending        (pending_q),
  .rd_ptr         (rdp_w),
  .wr_ptr         (wrp_w),
  .ring_start     (start_w),
  .seq            (seq_w),
  .host_wr_seq    (host_wr_seq_w),
  .host_wr_rdp    (host_wr_rdp_w)
);

// File: tb/rx_bufarea_ctrl_test.sv
`timescale 1ns/1ps
module rx_bufarea_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        pkt_end = 1'b0;
  logic [15:0] pkt_rem_words = 16'h0;
  logic        fetch_req;
  logic        fetch_ack = 1'b0;
  logic [31:0] fetch_addr;
  logic        last_in_area;
  logic        rsrc_exhausted;

  always #2 clk = ~clk;

  rx_bufarea_ctrl uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .wide_mode      (wide_mode),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .pkt_end        (pkt_end),
    .pkt_rem_words  (pkt_rem_words),
    .fetch_req      (fetch_req),
    .fetch_ack      (fetch_ack),
    .fetch_addr     (fetch_addr),
    .last_in_area   (last_in_area),
    .rsrc_exhausted (rsrc_exhausted)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    armed = 1'b0;
  bit    done  = 1'b0;

  // Behavioural reference state, plain integers.
  int m_thr, m_up, m_st, m_en, m_rd, m_wr, m_seq, m_rdata;
  bit m_pend, m_last;

  always @(posedge clk) begin
    int  wval;
    bit  take;
    bit  over;
    int  nxt;
    if (!rst_n) begin
      m_thr   <= 760;
      m_seq   <= 0;
      m_pend  <= 1'b0;
      m_last  <= 1'b0;
      m_rdata <= 0;
    end else begin
      take = m_pend && (m_rd != m_wr) && fetch_ack;
      over = pkt_end && (m_thr > int'(pkt_rem_words));
      case (reg_addr)
        3'd0: m_rdata <= m_thr;
        3'd1: m_rdata <= m_up;
        3'd2: m_rdata <= m_st;
        3'd3: m_rdata <= m_en;
        3'd4: m_rdata <= m_rd;
        3'd5: m_rdata <= m_wr;
        3'd6: m_rdata <= m_seq;
        default: m_rdata <= 0;
      endcase
      m_last <= over;
      m_pend <= (m_pend && !take) || over;
      wval = int'(reg_wdata);
      if (reg_we && reg_addr == 3'd6) m_seq <= wval;
      else if (take) m_seq <= (((m_seq / 256) + 1) % 256) * 256;
      else if (pkt_end) m_seq <= (m_seq / 256) * 256 + ((m_seq % 256) + 1) % 256;
      if (reg_we && reg_addr == 3'd4) m_rd <= wval - (wval % 2);
      else if (take) begin
        nxt = (m_rd + (wide_mode ? 16 : 8)) % 65536;
        m_rd <= (nxt == m_en) ? m_st : nxt;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_thr <= wval;
          3'd1: m_up  <= wval;
          3'd2: m_st  <= wval - (wval % 2);
          3'd3: m_en  <= wval - (wval % 2);
          3'd5: m_wr  <= wide_mode ? (wval - (wval % 4)) : (wval - (wval % 2));
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  // Cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (armed && rst_n && !done) begin
      bit er;
      er = m_pend && (m_rd != m_wr);
      cmp("fetch_req", fetch_req, er);
      cmp("rsrc_exhausted", rsrc_exhausted, m_pend && (m_rd == m_wr));
      cmp("last_in_area", last_in_area, m_last);
      cmp("reg_rdata", reg_rdata, m_rdata);
      if (er) cmp("fetch_addr", fetch_addr, longint'(m_up) * 65536 + m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    string keep;
    @(negedge clk);
    reg_addr = 3'(a);
    @(negedge clk);
    keep = phase; phase = tag;
    cmp("readback", reg_rdata, exp);
    phase = keep;
  endtask

  task automatic pkt(input int rem);
    @(negedge clk);
    pkt_end = 1'b1; pkt_rem_words = 16'(rem);
    @(negedge clk);
    pkt_end = 1'b0;
  endtask

  task automatic serve();
    int k;
    k = 0;
    while (!fetch_req && k < 50) begin
      @(negedge clk);
      k++;
    end
    fetch_ack = 1'b1;
    @(negedge clk);
    fetch_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values of threshold and sequence
    rd_chk("R1", 0, 16'h02F8);
    rd_chk("R1", 6, 16'h0000);
    phase = "R6";
    wr(1, 16'h1234); wr(2, 16'h0100); wr(3, 16'h0140);
    wr(4, 16'h0100); wr(5, 16'h0130);
    armed = 1'b1;
    // R6: pointer bit 0 not stored, map order
    wr(2, 16'h0101);
    rd_chk("R6", 2, 16'h0100);
    rd_chk("R6", 1, 16'h1234);
    rd_chk("R6", 3, 16'h0140);
    rd_chk("R6", 7, 16'h0000);
    // R2: free words above and equal to threshold keep the area
    phase = "R2";
    pkt(800);
    pkt(760);
    cmp("last_in_area", last_in_area, 0);
    rd_chk("R2", 6, 16'h0002);
    // R4: packet count wraps modulo 256
    phase = "R4";
    for (int i = 0; i < 300; i++) pkt(1000);
    rd_chk("R4", 6, 16'h002E);
    // R3 / R7: below threshold flags last frame and requests a descriptor
    phase = "R3";
    pkt(100);
    cmp("last_in_area", last_in_area, 1);
    phase = "R7";
    cmp("fetch_addr", fetch_addr, 32'h12340100);
    phase = "R5";
    serve();
    rd_chk("R5", 6, 16'h0100);
    // R8: narrow step of 8
    phase = "R8";
    rd_chk("R8", 4, 16'h0108);
    for (int i = 0; i < 5; i++) begin pkt(100); serve(); end
    rd_chk("R8", 4, 16'h0130);
    // R9: ring empty stalls the request, ack ignored
    phase = "R9";
    pkt(100);
    cmp("rsrc_exhausted", rsrc_exhausted, 1);
    cmp("fetch_req", fetch_req, 0);
    @(negedge clk); fetch_ack = 1'b1;
    @(negedge clk); fetch_ack = 1'b0;
    rd_chk("R9", 4, 16'h0130);
    wr(5, 16'h0118);
    cmp("fetch_req", fetch_req, 1);
    serve();
    phase = "R8";
    pkt(100); serve();
    rd_chk("R8", 4, 16'h0100);
    // R5: area count wraps from 255
    phase = "R5";
    wr(6, 16'hFF03);
    pkt(100);
    rd_chk("R5", 6, 16'hFF04);
    serve();
    rd_chk("R5", 6, 16'h0000);
    // R11: host write of zero clears, host write beats a frame end
    phase = "R11";
    wr(6, 16'h0505);
    wr(6, 16'h0000);
    rd_chk("R11", 6, 16'h0000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 16'h0A0A;
    pkt_end = 1'b1; pkt_rem_words = 16'd1000;
    @(negedge clk);
    reg_we = 1'b0; pkt_end = 1'b0;
    rd_chk("R11", 6, 16'h0A0A);
    // R10: wide mode drops write pointer bit 1; R8 wide step of 16
    phase = "R10";
    @(negedge clk); wide_mode = 1'b1;
    wr(5, 16'h0132);
    rd_chk("R10", 5, 16'h0130);
    wr(4, 16'h0100);
    phase = "R8";
    pkt(100); serve();
    rd_chk("R8", 4, 16'h0110);
    // R12: every register read one cycle after selection
    phase = "R12";
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); reg_addr = 3'(a);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule